// File: doc/BRIEF.md
# Multiplexed LCD Drive Waveform Sequencer

This block produces the drive-level codes for a one-third-duty multiplexed liquid-crystal panel with three common lines and thirty-two segment lines, so 96 picture elements are addressed. It runs from the display oscillator. Each oscillator tick is an enable on the system clock. The block does not generate analog levels. Each output is a three-bit code that names one supply rail, and an external level generator or analog multiplexer turns that code into a voltage.

A frame has three common slots. Exactly one common line is selected in each slot. The polarity of every level inverts on alternate frames, so the panel sees no net DC. Segment levels come from a copy of the display bits and the bias choice, and that copy is reloaded only at slot boundaries. Two flags act at once: blanking forces every segment to the dark level while timing continues, and low-power mode drives every output to the bottom rail and freezes the sequencer.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the sequencer is in slot 0 with positive polarity, the held display bits are all zero and the held bias is 1/3. The common codes are therefore {com2,com1,com0} = {1,1,4} and every segment code is 3.
- R2: A slot lasts 128 accepted ticks. Slots run 0, 1, 2 and then wrap, so a frame is 384 ticks. A tick counts only when `osc_tick` is 1 and `low_power` is 0.
- R3: Polarity starts positive and inverts at every frame end. Positive means the selected common is at code 4 and a lit segment is at code 0. Negative means the selected common is at 0 and a lit segment is at 4.
- R4: Level codes are 0 = VSS, 1 = one third, 2 = one half, 3 = two thirds, 4 = VDD. With 1/3 bias, a non-selected common is at 1 in positive polarity and at 3 in negative polarity.
- R5: With 1/2 bias (`bias_half` = 1), every non-selected common is at 2. An unlit segment takes the same code as the selected common.
- R6: Segment s in slot c is lit when display bit index c*32+s is 1. With 1/3 bias an unlit segment is at 3 in positive polarity and at 1 in negative polarity.
- R7: While `blank` is 1, every segment shows the unlit level from the next clock sample onward, and the slot and frame timing keep running.
- R8: While `low_power` is 1, every common and segment code is 0 and the sequencer state does not advance. When the flag is released, operation resumes from the frozen state.
- R9: A change on `disp_bits` or `bias_half` reaches the outputs only at the next slot boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Display oscillator enable, one pulse per oscillator cycle |
| disp_bits | input | 96 | Display bits, index c*32+s for common c and segment s |
| bias_half | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| blank | input | 1 | Forces all segments to the unlit level |
| low_power | input | 1 | Drives all outputs to VSS and freezes timing |
| com_lvl | output | 9 | Level code per common line, com c at bits [3c+2:3c] |
| seg_lvl | output | 96 | Level code per segment line, segment s at bits [3s+2:3s] |

## Verification
The bench targets the slot edges at tick 127 and tick 128. A design with an off-by-one slot length would move the selection a cycle early or late. It also targets the frame edge at 384 ticks, where a design that forgot to invert polarity would put DC across the panel. It changes data and bias in the middle of a slot, so a design that does not hold them until the boundary shows new levels too early. Blanking and low power are applied mid-slot and then released. A design that stopped timing during blanking, or kept counting during low power, would come out of either one in the wrong slot.

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NUM_COM    = 3,
  parameter int NUM_SEG    = 32,
  parameter int SLOT_TICKS = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_tick,
  input  logic [NUM_COM*NUM_SEG-1:0] disp_bits,
  input  logic                       bias_half,
  input  logic                       blank,
  input  logic                       low_power,
  output logic [NUM_COM*3-1:0]       com_lvl,
  output logic [NUM_SEG*3-1:0]       seg_lvl
);

  localparam int CW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam int SW = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;
  localparam logic [2:0] LV_VSS  = 3'd0;
  localparam logic [2:0] LV_ONE  = 3'd1;
  localparam logic [2:0] LV_HALF = 3'd2;
  localparam logic [2:0] LV_TWO  = 3'd3;
  localparam logic [2:0] LV_VDD  = 3'd4;

  logic [CW-1:0]                   tick_q;
  logic [SW-1:0]                   slot_q;
  logic                            pol_q;
  logic                            half_q;
  logic [NUM_COM-1:0][NUM_SEG-1:0] shadow_q;

  wire step      = osc_tick && !low_power;
  wire slot_end  = step && (tick_q == CW'(SLOT_TICKS - 1));
  wire frame_end = slot_end && (slot_q == SW'(NUM_COM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q   <= '0;
      slot_q   <= '0;
      pol_q    <= 1'b0;
      half_q   <= 1'b0;
      shadow_q <= '0;
    end else if (step) begin
      tick_q <= slot_end ? '0 : tick_q + 1'b1;
      if (slot_end) begin
        slot_q   <= frame_end ? '0 : slot_q + 1'b1;
        shadow_q <= disp_bits;
        half_q   <= bias_half;
      end
      if (frame_end) pol_q <= ~pol_q;
    end
  end

  wire [2:0] sel_c  = pol_q ? LV_VSS : LV_VDD;
  wire [2:0] lit_s  = pol_q ? LV_VDD : LV_VSS;
  wire [2:0] idle_c = half_q ? LV_HALF : (pol_q ? LV_TWO : LV_ONE);
  wire [2:0] dark_s = half_q ? sel_c : (pol_q ? LV_ONE : LV_TWO);
  wire [NUM_SEG-1:0] row = shadow_q[slot_q];

  genvar c, s;
  generate
    for (c = 0; c < NUM_COM; c++) begin : g_com
      assign com_lvl[c*3 +: 3] = low_power ? LV_VSS :
                                 (slot_q == SW'(c)) ? sel_c : idle_c;
    end
    for (s = 0; s < NUM_SEG; s++) begin : g_seg
      assign seg_lvl[s*3 +: 3] = low_power ? LV_VSS :
                                 (row[s] && !blank) ? lit_s : dark_s;
    end
  endgenerate

  logic [NUM_COM-1:0] rail_mask;
  always_comb begin
    for (int i = 0; i < NUM_COM; i++)
      rail_mask[i] = (com_lvl[i*3 +: 3] == LV_VSS) || (com_lvl[i*3 +: 3] == LV_VDD);
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SW'(NUM_COM)); // R2
  AST_LP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> ($stable(tick_q) && $stable(slot_q) && $stable(pol_q))); // R8
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pol_q != $past(pol_q))); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> ($stable(shadow_q) && $stable(half_q))); // R9
  AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |-> ($countones(rail_mask) == 1)); // R4

endmodule

// File: tb/lcd_mux_seq_tb.sv
`timescale 1ns/1ps
module lcd_mux_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic [95:0] disp_bits = '0;
  logic bias_half = 1'b0;
  logic blank = 1'b0;
  logic low_power = 1'b0;
  logic [8:0]  com_lvl;
  logic [95:0] seg_lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_mux_seq dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .disp_bits(disp_bits),
    .bias_half(bias_half), .blank(blank), .low_power(low_power),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  int          m_tick, m_slot;
  bit          m_pol, m_half;
  logic [95:0] m_sh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick = 0; m_slot = 0; m_pol = 0; m_half = 0; m_sh = '0;
    end else if (osc_tick && !low_power) begin
      if (m_tick == 127) begin
        m_tick = 0;
        m_sh = disp_bits;
        m_half = bias_half;
        if (m_slot == 2) begin m_slot = 0; m_pol = !m_pol; end
        else m_slot = m_slot + 1;
      end else m_tick = m_tick + 1;
    end
  end

  function automatic logic [2:0] e_com(int c);
    if (low_power) return 3'd0;
    if (c == m_slot) return m_pol ? 3'd0 : 3'd4;
    return m_half ? 3'd2 : (m_pol ? 3'd3 : 3'd1);
  endfunction

  function automatic logic [2:0] e_seg(int s);
    if (low_power) return 3'd0;
    if (m_sh[m_slot*32+s] && !blank) return m_pol ? 3'd4 : 3'd0;
    if (m_half) return m_pol ? 3'd0 : 3'd4;
    return m_pol ? 3'd1 : 3'd3;
  endfunction

  task automatic cmp(string tag, logic [127:0] act, logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [8:0]  ec;
    logic [95:0] es;
    for (int c = 0; c < 3; c++) ec[c*3 +: 3] = e_com(c);
    for (int s = 0; s < 32; s++) es[s*3 +: 3] = e_seg(s);
    cmp({tag, " com"}, {119'd0, com_lvl}, {119'd0, ec});
    cmp({tag, " seg"}, {32'd0, seg_lvl}, {32'd0, es});
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  localparam logic [97:0] VEC [6] = '{
    {1'b0, 1'b0, 96'hFFFFFFFF_FFFFFFFF_FFFFFFFF},
    {1'b0, 1'b0, 96'hFFFFFFFF_00000000_12345678},
    {1'b1, 1'b0, 96'hA5A5A5A5_0F0F0F0F_80000001},
    {1'b1, 1'b1, 96'h5A5A5A5A_F0F0F0F0_7FFFFFFE},
    {1'b0, 1'b1, 96'hDEADBEEF_CAFEF00D_01234567},
    {1'b0, 1'b0, 96'h00000000_FFFF0000_0000FFFF}
  };

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset com", {119'd0, com_lvl}, {119'd0, 9'b001_001_100});
    cmp("R1 reset seg", {32'd0, seg_lvl}, {32'd0, {32{3'd3}}});
    check_all("R1");

    osc_tick = 1'b1;
    cycles(127);
    cmp("R2 tick127 com0", {125'd0, com_lvl[2:0]}, {125'd0, 3'd4});
    cycles(1);
    cmp("R2 tick128 com1", {125'd0, com_lvl[5:3]}, {125'd0, 3'd4});
    cmp("R2 tick128 com0", {125'd0, com_lvl[2:0]}, {125'd0, 3'd1});
    cycles(256);
    cmp("R3 frame flip com0", {125'd0, com_lvl[2:0]}, {125'd0, 3'd0});
    cmp("R4 neg idle com1", {125'd0, com_lvl[5:3]}, {125'd0, 3'd3});
    cmp("R6 neg dark seg", {125'd0, seg_lvl[2:0]}, {125'd0, 3'd1});

    osc_tick = 1'b0;
    cycles(60);
    check_all("R2 no tick");
    osc_tick = 1'b1;
    cycles(40);

    for (int v = 0; v < 6; v++) begin
      string tag;
      tag = VEC[v][97] ? "R5" : (VEC[v][96] ? "R7" : "R6");
      bias_half = VEC[v][97];
      blank     = VEC[v][96];
      disp_bits = VEC[v][95:0];
      cycles(1);
      check_all("R9 held");
      cycles(130);
      check_all(tag);
      cycles(200);
      check_all(tag);
    end

    blank = 1'b0;
    disp_bits = {96{1'b1}};
    cycles(140);
    check_all("R6 lit");
    blank = 1'b1;
    cycles(1);
    check_all("R7 blank now");
    cycles(200);
    check_all("R7 timing runs");
    blank = 1'b0;
    cycles(1);
    check_all("R7 release");

    cycles(50);
    low_power = 1'b1;
    cycles(1);
    cmp("R8 lp com", {119'd0, com_lvl}, 128'd0);
    cmp("R8 lp seg", {32'd0, seg_lvl}, 128'd0);
    cycles(300);
    cmp("R8 lp hold seg", {32'd0, seg_lvl}, 128'd0);
    low_power = 1'b0;
    cycles(1);
    check_all("R8 resume");
    cycles(150);
    check_all("R8 resume later");

    rst_n = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    bias_half = 1'b0;
    osc_tick = 1'b0;
    cycles(1);
    cmp("R1 rerun com", {119'd0, com_lvl}, {119'd0, 9'b001_001_100});
    cmp("R1 rerun seg", {32'd0, seg_lvl}, {32'd0, {32{3'd3}}});
    finish_run();
  end
endmodule